// File: doc/BRIEF.md
# Serial Multi-Word Magnitude Comparator

This block decides whether one wide unsigned operand is less than, equal to or greater than another. Both operands sit in external word-wide memories with a synchronous read port. The block drives one address bus into both memories, so the same word of each operand comes back together. It takes in one word pair per clock. A wide operand therefore costs one comparator the width of a single word, plus a small sequencer.

A single-cycle start pulse begins a scan, and only a pulse that arrives while the block is idle is taken. The scan begins at the most significant word and works down to word 0, which holds the least significant bits. The first word pair that differs fixes the verdict. If no pair differs, the verdict is equal. While the scan runs, the ready output is low. When ready returns high, exactly one of the three flags is set, and the flags keep that value until a later scan completes.

Top module: `serial_magcmp`

## Requirements
- R1: After reset, ready is 1, eq is 1, and lt and gt are both 0.
- R2: A start pulse seen while ready is 1 is accepted, and ready then reads 0 from the next cycle until the scan completes.
- R3: Starting the cycle after an accepted start, rd_addr presents NUM_WORDS-1, then decreases by one each cycle down to 0, and drives both operand memories.
- R4: Data for an address is taken one cycle after that address is presented, matching a synchronous read with a latency of one clock.
- R5: Once ready is 1, exactly one of lt, eq and gt is 1, and it matches the unsigned comparison of X with Y. Word i occupies bits [i*WORD_W +: WORD_W] of its operand, so word 0 is the least significant word.
- R6: The most significant word pair that differs decides the result, even when less significant words differ in the opposite direction.
- R7: Ready rises NUM_WORDS+1 clock edges after the edge that accepts start.
- R8: While ready is 1 and no start is given, the flags hold their values, even if the memory contents change.
- R9: A start pulse that arrives while ready is 0 is ignored. It neither restarts the scan nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a comparison |
| ready | output | 1 | High when idle and the flags are valid |
| rd_addr | output | ADDR_W | Word address shared by the X and Y memories |
| x_word | input | WORD_W | Read data from the X memory, one cycle after rd_addr |
| y_word | input | WORD_W | Read data from the Y memory, one cycle after rd_addr |
| lt | output | 1 | X is less than Y |
| eq | output | 1 | X equals Y |
| gt | output | 1 | X is greater than Y |

## Verification
The bench builds the comparator with 32-bit words and eight words per operand, which gives 256-bit operands and a 3-bit address. With eight words, a difference can be placed in the least significant word, in a middle word or in the top word. It can also be set against an opposing difference lower down, which exercises the priority of the first differing word in both directions. The nine-cycle scan leaves room to inject a start pulse part-way through and to check that it neither restarts nor stretches the scan.

// File: rtl/serial_magcmp_pkg.sv
package serial_magcmp_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2
  } rel_e;

  // Map a verdict onto the {lt, eq, gt} flag bundle.
  function automatic logic [2:0] rel_flags(rel_e r);
    case (r)
      REL_LT:  return 3'b100;
      REL_GT:  return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

endpackage

// File: rtl/serial_magcmp_seq.sv
module serial_magcmp_seq #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic              accept,
  output logic              issuing,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              data_valid,
  output logic              data_last
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_WORDS - 1);

  logic busy;

  assign accept = start && !busy;
  assign ready  = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      issuing    <= 1'b0;
      rd_addr    <= '0;
      data_valid <= 1'b0;
      data_last  <= 1'b0;
    end else begin
      // Tag the word returned by the memory one cycle after its address.
      data_valid <= issuing;
      data_last  <= issuing && (rd_addr == '0);
      if (accept) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        rd_addr <= TOP_ADDR;
      end else if (issuing) begin
        if (rd_addr == '0) issuing <= 1'b0;
        else               rd_addr <= rd_addr - 1'b1;
      end
      if (data_valid && data_last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_magcmp_word.sv
module serial_magcmp_word
  import serial_magcmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output rel_e              rel
);
  function automatic rel_e word_cmp(logic [WORD_W-1:0] p, logic [WORD_W-1:0] q);
    if (p < q)      return REL_LT;
    else if (p > q) return REL_GT;
    else            return REL_EQ;
  endfunction

  assign rel = word_cmp(a, b);
endmodule

// File: rtl/serial_magcmp_acc.sv
module serial_magcmp_acc
  import serial_magcmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic data_valid,
  input  logic data_last,
  input  rel_e word_rel,
  output rel_e result
);
  rel_e running;
  rel_e merged;

  // The first differing word pair seen from the top keeps the verdict.
  assign merged = (running == REL_EQ) ? word_rel : running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= REL_EQ;
      result  <= REL_EQ;
    end else begin
      if (clear)           running <= REL_EQ;
      else if (data_valid) running <= merged;
      if (data_valid && data_last) result <= merged;
    end
  end
endmodule

// File: rtl/serial_magcmp.sv
module serial_magcmp
  import serial_magcmp_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] x_word,
  input  logic [WORD_W-1:0] y_word,
  output logic              lt,
  output logic              eq,
  output logic              gt
);
  logic start_accept;
  logic addr_issue;
  logic word_valid;
  logic word_last;
  rel_e word_rel;
  rel_e verdict;

  serial_magcmp_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .accept(start_accept), .issuing(addr_issue), .rd_addr(rd_addr),
    .data_valid(word_valid), .data_last(word_last)
  );

  serial_magcmp_word #(.WORD_W(WORD_W)) u_word (
    .a(x_word), .b(y_word), .rel(word_rel)
  );

  serial_magcmp_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear(start_accept),
    .data_valid(word_valid), .data_last(word_last),
    .word_rel(word_rel), .result(verdict)
  );

  assign {lt, eq, gt} = rel_flags(verdict);
endmodule

// File: rtl/serial_magcmp_chk.sv
module serial_magcmp_chk #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic              accept,
  input logic              issuing,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              lt,
  input logic              eq,
  input logic              gt
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (ready) busy_cnt <= '0;
    else            busy_cnt <= busy_cnt + 16'd1;
  end

  p_onehot_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lt, eq, gt}) == 1);

  p_busy_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(start));

  p_addr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_addr == ADDR_W'(NUM_WORDS - 1));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issuing && rd_addr != '0) |=> rd_addr == ADDR_W'($past(rd_addr) - 1'b1));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_cnt == 16'(NUM_WORDS + 1));

  p_hold_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable({lt, eq, gt}));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ready && !issuing) |=> !issuing);
endmodule

bind serial_magcmp serial_magcmp_chk #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .accept(start_accept), .issuing(addr_issue), .rd_addr(rd_addr),
  .lt(lt), .eq(eq), .gt(gt)
);

// File: tb/serial_magcmp_test.sv
`timescale 1ns/1ps
module serial_magcmp_test;
  localparam int W  = 32;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int OW = W * N;
  localparam int NV = 7;

  // Per-vector: which word of Y is nudged (-1: none), and by how much.
  localparam int VWORD[NV]  = '{-1, 0, 0, 3, 3, 7, 7};
  localparam int VDELTA[NV] = '{ 0, 1, -1, 1, -1, 1, -1};
  localparam logic [OW-1:0] BASE[2] = '{
    256'h6E21A4C9_13F0BB72_8D5C0E31_47A9D2F6_2B7E6619_C0453D8A_95E1F704_3A6C29DB,
    256'h1D83F5A2_7C04E9B1_A3362F58_0E9BC74D_F1275A03_5D90C6E8_40AF1B37_C82E6D95
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic ready;
  logic [AW-1:0] rd_addr;
  logic [W-1:0] x_q, y_q;
  logic lt, eq, gt;
  logic [W-1:0] xmem[N];
  logic [W-1:0] ymem[N];

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    x_q <= xmem[rd_addr];
    y_q <= ymem[rd_addr];
  end

  serial_magcmp uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .rd_addr(rd_addr), .x_word(x_q), .y_word(y_q),
    .lt(lt), .eq(eq), .gt(gt)
  );

  // Expected {lt, eq, gt} from a wide subtraction and its borrow.
  function automatic logic [2:0] ref_flags(logic [OW-1:0] a, logic [OW-1:0] b);
    logic [OW:0] d;
    d = {1'b0, a} - {1'b0, b};
    if (d[OW])      return 3'b100;
    else if (d == 0) return 3'b010;
    else            return 3'b001;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(logic [OW-1:0] x, logic [OW-1:0] y);
    for (int i = 0; i < N; i++) begin
      xmem[i] = x[i*W +: W];
      ymem[i] = y[i*W +: W];
    end
  endtask

  task automatic run_op(input bit chk_addr, output int lat);
    int cyc;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    chk("R2 ready low after start", 64'(ready), 64'd0);
    while (!ready && cyc < 200) begin
      if (chk_addr && cyc - 1 < N) chk("R3 address order", 64'(rd_addr), 64'(N - cyc));
      @(negedge clk);
      cyc++;
    end
    lat = cyc - 1;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [OW-1:0] x, y;
    start = 1'b0;
    rst_n = 1'b0;
    load('0, '0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", 64'(ready), 64'd1);
    chk("R1 flags", 64'({lt, eq, gt}), 64'b010);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R4: table of vectors over two base operands
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < NV; v++) begin
        x = BASE[b];
        y = x;
        if (VWORD[v] >= 0)
          y[VWORD[v]*W +: W] = W'(int'(x[VWORD[v]*W +: W]) + VDELTA[v]);
        load(x, y);
        run_op(b == 0 && v == 0, lat);
        chk("R7 latency", 64'(lat), 64'(N + 1));
        chk("R5 flags", 64'({lt, eq, gt}), 64'(ref_flags(x, y)));
      end
    end

    // R6: top differing word wins over an opposite lower difference
    x = BASE[0];
    y = x;
    y[6*W +: W] = y[6*W +: W] - 1;
    y[0 +: W]   = y[0 +: W] + 5;
    load(x, y);
    run_op(1'b0, lat);
    chk("R6 priority gt", 64'({lt, eq, gt}), 64'b001);
    x = BASE[1];
    y = x;
    y[5*W +: W] = y[5*W +: W] + 1;
    y[1*W +: W] = y[1*W +: W] - 9;
    load(x, y);
    run_op(1'b0, lat);
    chk("R6 priority lt", 64'({lt, eq, gt}), 64'b100);

    // R9: start during a scan is ignored
    x = BASE[1];
    y = x;
    y[2*W +: W] = y[2*W +: W] - 1;
    load(x, y);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat++;
    while (!ready && lat < 200) begin @(negedge clk); lat++; end
    chk("R9 latency unchanged", 64'(lat - 1), 64'(N + 1));
    chk("R9 result", 64'({lt, eq, gt}), 64'b001);

    // R8: flags hold while idle even when memories change
    load(BASE[1], BASE[0]);
    repeat (12) @(negedge clk);
    chk("R8 hold flags", 64'({lt, eq, gt}), 64'b001);
    chk("R8 ready idle", 64'(ready), 64'd1);

    // R4 R5: the new contents are seen by the next scan
    run_op(1'b0, lat);
    chk("R5 after reload", 64'({lt, eq, gt}), 64'(ref_flags(BASE[1], BASE[0])));

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule